// File: doc/BRIEF.md
# Serial Configuration Image Loader

At reset time this block walks a serial configuration memory byte by byte from address zero. It interprets the bytes as a chain of typed blocks and turns them into 32-bit register writes. A block is either a single register write or a counted burst of writes to consecutive registers. The chain ends with a terminator block, and a checksum byte follows the terminator. An 8-bit running sum taken over every byte read must come to 0xFF before the image counts as good.

When the load finishes, the block pulses `done`, reports a result code, and raises `released`, which lets the rest of the device leave reset. The byte-level memory access engine sits outside the block and is reached through a request/response pair. The register space sits outside too and is reached through a write port.

All three data interfaces use valid/ready:
- A transfer completes on a clock edge where both valid and ready are high.
- A producer holds valid and its payload steady until that edge.
- The loader keeps at most one read in flight.
- It never issues a read while a register write is waiting on `wr_ready`.
- Holding `rd_req_ready`, `rd_rsp_valid` or `wr_ready` low stalls the load for as long as needed, and nothing is lost.

Top module: `eel_loader`

## Requirements
- R1: Out of reset, `busy`, `done`, `released`, `cksum_fail`, `rd_req_valid` and `wr_valid` are low and `err_code` is 0.
- R2: After an accepted `start`, read requests carry addresses 0, 1, 2, … in strict order. There is one request per byte, and the next request follows the response to the previous one. A request held without `rd_req_ready` keeps its address.
- R3: Each block opens with a header. In header byte 0, bits 1:0 are the type and bits 7:2 are register byte address bits 7:2. In header byte 1, bits 5:0 are address bits 13:8 and bits 7:6 are ignored. Type 0 is followed by four data bytes, least significant first, and produces one write to that address.
- R4: Type 1 is followed by a 16-bit count, low byte first, and then that many dwords, each least significant byte first. Dword i is written to the header address plus 4·i, wrapping within the 14-bit register address space.
- R5: A type 1 block with count 0 writes nothing, and the byte after its count is read as the next header.
- R6: Type 2 ends the chain. Its two header bytes are followed by one checksum byte. If the 8-bit sum of all bytes from address 0 through the checksum byte is 0xFF, `err_code` is 0. Otherwise `err_code` is 1 and `cksum_fail` is high. Writes already issued are not undone.
- R7: Type 3 in a header aborts the load with `err_code` 2. No read follows that header byte, and no write follows it either.
- R8: The loader never requests an address at or above `MEM_BYTES`. If it needs a byte there, the load ends with `err_code` 3.
- R9: A load ends with `done` high for exactly one cycle, `busy` low, and `released` high. `released` stays high until the next accepted `start`. A `start` while `busy` is ignored.
- R10: `wr_valid` holds with steady `wr_addr` and `wr_data` until `wr_ready`, and no read request is raised while a write is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a load (taken only while idle) |
| busy | output | 1 | Load in progress |
| done | output | 1 | One-cycle pulse when a load ends |
| released | output | 1 | Device may leave reset |
| err_code | output | 2 | 0 ok, 1 checksum, 2 reserved type, 3 overrun |
| cksum_fail | output | 1 | High when the last load failed its checksum |
| rd_req_valid | output | 1 | Byte read request valid |
| rd_req_ready | input | 1 | Reader accepts the request |
| rd_req_addr | output | EE_AW | Byte address to read |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_ready | output | 1 | Loader accepts read data |
| rd_rsp_data | input | 8 | Read data byte |
| wr_valid | output | 1 | Register write valid |
| wr_ready | input | 1 | Register space accepts the write |
| wr_addr | output | 14 | Register byte address (bits 1:0 zero) |
| wr_data | output | 32 | Register write data |

## Verification
Burst lengths 0 through 5 are swept behind a single write, and every data word and address is computed arithmetically. This separates the count decode, the byte order within a dword, the address stepping and the zero-count skip. A burst that crosses the top of the register address space checks the wrap. A deliberately wrong checksum byte, a reserved header and an image with no terminator each end the load through a different result code, and the number of bytes read shows where the walk stopped. Every run uses pseudo-random stalls on all three handshakes, and one run pokes `start` mid-load to show it is ignored.

// File: rtl/eel_pkg.sv
package eel_pkg;
  // register byte address width and derived dword address width
  localparam int SYS_AW = 14;
  localparam int DWA_W  = SYS_AW - 2;
  localparam int CNT_W  = 16;

  typedef enum logic [1:0] {
    BT_SINGLE = 2'd0,
    BT_BURST  = 2'd1,
    BT_END    = 2'd2,
    BT_RSVD   = 2'd3
  } blk_type_e;

  typedef enum logic [1:0] {
    ERR_NONE    = 2'd0,
    ERR_SUM     = 2'd1,
    ERR_TYPE    = 2'd2,
    ERR_OVERRUN = 2'd3
  } load_err_e;

  typedef enum logic [2:0] {
    P_IDLE, P_HDR0, P_HDR1, P_CNT0, P_CNT1, P_DATA, P_WR, P_SUM
  } parse_st_e;

  typedef enum logic [1:0] {
    F_IDLE, F_REQ, F_RSP
  } fetch_st_e;
endpackage

// File: rtl/eel_fetch.sv
module eel_fetch import eel_pkg::*; #(
  parameter int MEM_BYTES = 65536,
  parameter int EE_AW     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             want,
  output logic             rd_req_valid,
  input  logic             rd_req_ready,
  output logic [EE_AW-1:0] rd_req_addr,
  input  logic             rd_rsp_valid,
  output logic             rd_rsp_ready,
  input  logic [7:0]       rd_rsp_data,
  output logic             byte_vld,
  output logic [7:0]       byte_data,
  output logic             overrun
);
  localparam int PTR_W = $clog2(MEM_BYTES + 1);
  localparam logic [PTR_W-1:0] LIMIT = PTR_W'(MEM_BYTES);

  fetch_st_e        st_q;
  logic [PTR_W-1:0] ptr_q;

  // a byte is needed but the pointer sits past the last valid address
  assign overrun      = (st_q == F_IDLE) && want && (ptr_q == LIMIT);
  assign rd_req_valid = (st_q == F_REQ);
  assign rd_req_addr  = EE_AW'(ptr_q);
  assign rd_rsp_ready = (st_q == F_RSP);
  assign byte_vld     = (st_q == F_RSP) && rd_rsp_valid;
  assign byte_data    = rd_rsp_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= F_IDLE;
      ptr_q <= '0;
    end else if (clr) begin
      st_q  <= F_IDLE;
      ptr_q <= '0;
    end else begin
      case (st_q)
        F_IDLE: if (want && (ptr_q != LIMIT)) st_q <= F_REQ;
        F_REQ:  if (rd_req_ready) st_q <= F_RSP;
        F_RSP:  if (rd_rsp_valid) begin
                  st_q  <= F_IDLE;
                  ptr_q <= ptr_q + 1'b1;
                end
        default: st_q <= F_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eel_sum.sv
module eel_sum (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       add_vld,
  input  logic [7:0] add_byte,
  output logic [7:0] sum_next
);
  logic [7:0] acc_q;

  // sum including the byte being delivered this cycle
  assign sum_next = acc_q + add_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       acc_q <= '0;
    else if (clr)     acc_q <= '0;
    else if (add_vld) acc_q <= sum_next;
  end
endmodule

// File: rtl/eel_parse.sv
module eel_parse import eel_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              byte_vld,
  input  logic [7:0]        byte_data,
  input  logic              overrun,
  input  logic [7:0]        sum_next,
  input  logic              wr_ready,
  output logic              want,
  output logic              busy,
  output logic              done,
  output logic              released,
  output load_err_e         err,
  output logic              wr_valid,
  output logic [SYS_AW-1:0] wr_addr,
  output logic [31:0]       wr_data
);
  parse_st_e        st_q;
  blk_type_e        typ_q;
  logic [DWA_W-1:0] dwa_q;
  logic [CNT_W-1:0] cnt_q;
  logic [31:0]      dw_q;
  logic [1:0]       bidx_q;
  logic             done_q, rel_q;
  load_err_e        err_q;

  assign busy     = (st_q != P_IDLE);
  assign want     = busy && (st_q != P_WR);
  assign done     = done_q;
  assign released = rel_q;
  assign err      = err_q;
  assign wr_valid = (st_q == P_WR);
  assign wr_addr  = {dwa_q, 2'b00};
  assign wr_data  = dw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= P_IDLE;
      typ_q  <= BT_SINGLE;
      dwa_q  <= '0;
      cnt_q  <= '0;
      dw_q   <= '0;
      bidx_q <= '0;
      done_q <= 1'b0;
      rel_q  <= 1'b0;
      err_q  <= ERR_NONE;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        P_IDLE: begin
          if (go) begin
            st_q  <= P_HDR0;
            err_q <= ERR_NONE;
            rel_q <= 1'b0;
          end
        end
        P_WR: begin
          if (wr_ready) begin
            dwa_q  <= dwa_q + 1'b1;
            cnt_q  <= cnt_q - 1'b1;
            bidx_q <= '0;
            st_q   <= (cnt_q == CNT_W'(1)) ? P_HDR0 : P_DATA;
          end
        end
        default: begin
          if (overrun) begin
            st_q   <= P_IDLE;
            done_q <= 1'b1;
            rel_q  <= 1'b1;
            err_q  <= ERR_OVERRUN;
          end else if (byte_vld) begin
            case (st_q)
              P_HDR0: begin
                typ_q      <= blk_type_e'(byte_data[1:0]);
                dwa_q[5:0] <= byte_data[7:2];
                if (blk_type_e'(byte_data[1:0]) == BT_RSVD) begin
                  st_q   <= P_IDLE;
                  done_q <= 1'b1;
                  rel_q  <= 1'b1;
                  err_q  <= ERR_TYPE;
                end else begin
                  st_q <= P_HDR1;
                end
              end
              P_HDR1: begin
                dwa_q[DWA_W-1:6] <= byte_data[DWA_W-7:0];
                bidx_q           <= '0;
                case (typ_q)
                  BT_SINGLE: begin
                    cnt_q <= CNT_W'(1);
                    st_q  <= P_DATA;
                  end
                  BT_BURST: st_q <= P_CNT0;
                  default:  st_q <= P_SUM;
                endcase
              end
              P_CNT0: begin
                cnt_q[7:0] <= byte_data;
                st_q       <= P_CNT1;
              end
              P_CNT1: begin
                cnt_q[15:8] <= byte_data;
                bidx_q      <= '0;
                st_q        <= ({byte_data, cnt_q[7:0]} == '0) ? P_HDR0 : P_DATA;
              end
              P_DATA: begin
                dw_q[8*bidx_q +: 8] <= byte_data;
                bidx_q              <= bidx_q + 1'b1;
                if (bidx_q == 2'd3) st_q <= P_WR;
              end
              P_SUM: begin
                st_q   <= P_IDLE;
                done_q <= 1'b1;
                rel_q  <= 1'b1;
                err_q  <= (sum_next == 8'hFF) ? ERR_NONE : ERR_SUM;
              end
              default: st_q <= P_IDLE;
            endcase
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/eel_loader.sv
module eel_loader import eel_pkg::*; #(
  parameter int MEM_BYTES = 65536,
  parameter int EE_AW     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              released,
  output logic [1:0]        err_code,
  output logic              cksum_fail,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [EE_AW-1:0]  rd_req_addr,
  input  logic              rd_rsp_valid,
  output logic              rd_rsp_ready,
  input  logic [7:0]        rd_rsp_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [SYS_AW-1:0] wr_addr,
  output logic [31:0]       wr_data
);
  logic      go, want, byte_vld, overrun;
  logic [7:0] byte_data, sum_next;
  load_err_e err;

  assign go         = start && !busy;
  assign err_code   = err;
  assign cksum_fail = (err == ERR_SUM);

  eel_fetch #(.MEM_BYTES(MEM_BYTES), .EE_AW(EE_AW)) u_fetch (
    .clk(clk), .rst_n(rst_n), .clr(go), .want(want),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready), .rd_rsp_data(rd_rsp_data),
    .byte_vld(byte_vld), .byte_data(byte_data), .overrun(overrun)
  );

  eel_sum u_sum (
    .clk(clk), .rst_n(rst_n), .clr(go),
    .add_vld(byte_vld), .add_byte(byte_data), .sum_next(sum_next)
  );

  eel_parse u_parse (
    .clk(clk), .rst_n(rst_n), .go(go),
    .byte_vld(byte_vld), .byte_data(byte_data), .overrun(overrun), .sum_next(sum_next),
    .wr_ready(wr_ready), .want(want), .busy(busy), .done(done), .released(released),
    .err(err), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
  );
endmodule

// File: rtl/eel_loader_chk.sv
module eel_loader_chk #(
  parameter int MEM_BYTES = 65536,
  parameter int EE_AW     = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             released,
  input logic             cksum_fail,
  input logic             rd_req_valid,
  input logic             rd_req_ready,
  input logic [EE_AW-1:0] rd_req_addr,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic [13:0]      wr_addr,
  input logic [31:0]      wr_data
);
  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));

  p_read_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> (int'(rd_req_addr) < MEM_BYTES));

  p_wr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  p_no_read_in_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !rd_req_valid);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_req_valid && !wr_valid);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> released && !busy);

  p_fail_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cksum_fail |-> released && !busy);
endmodule

bind eel_loader eel_loader_chk #(.MEM_BYTES(MEM_BYTES), .EE_AW(EE_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .released(released),
  .cksum_fail(cksum_fail), .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
  .rd_req_addr(rd_req_addr), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_addr(wr_addr), .wr_data(wr_data)
);

// File: tb/tb_eel_loader.sv
module tb_eel_loader;
  localparam int MEMB = 64;

  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic        busy, done, released, cksum_fail;
  logic [1:0]  err_code;
  logic        rd_req_valid, rd_rsp_ready, wr_valid;
  logic        rd_req_ready = 1'b0, rd_rsp_valid = 1'b0, wr_ready = 1'b0;
  logic [15:0] rd_req_addr;
  logic [7:0]  rd_rsp_data = 8'h00;
  logic [13:0] wr_addr;
  logic [31:0] wr_data;

  eel_loader #(.MEM_BYTES(MEMB)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .released(released), .err_code(err_code), .cksum_fail(cksum_fail),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready), .rd_rsp_data(rd_rsp_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always #2 clk = ~clk;

  logic [7:0]  img [MEMB];
  logic [13:0] ea [MEMB];
  logic [31:0] ed [MEMB];
  logic [13:0] ga [MEMB];
  logic [31:0] gd [MEMB];
  int bp = 0, en = 0, gn = 0, rd_cnt = 0, rd_bad = 0;
  int checks = 0, fails = 0, cyc = 0;
  logic        pend = 1'b0;
  logic [15:0] paddr = 16'h0;
  logic [15:0] lfsr = 16'hACE1;

  // memory reader and register sink models, all decided away from the edge
  always @(negedge clk) begin
    cyc++;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (!rst_n) begin
      rd_req_ready = 1'b0; rd_rsp_valid = 1'b0; wr_ready = 1'b0; pend = 1'b0;
    end else begin
      if (pend) begin
        rd_rsp_valid = lfsr[0] | lfsr[3];
        rd_rsp_data  = img[paddr[5:0]];
        if (rd_rsp_valid && rd_rsp_ready) pend = 1'b0;
      end else begin
        rd_rsp_valid = 1'b0;
      end
      rd_req_ready = lfsr[1] | lfsr[5];
      if (rd_req_valid && rd_req_ready) begin
        if (rd_req_addr != 16'(rd_cnt)) rd_bad++;
        rd_cnt++;
        pend  = 1'b1;
        paddr = rd_req_addr;
      end
      wr_ready = lfsr[2] | lfsr[7];
      if (wr_valid && wr_ready) begin
        if (gn < MEMB) begin ga[gn] = wr_addr; gd[gn] = wr_data; end
        gn++;
      end
    end
  end

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(negedge clk) begin
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung actual=%0d expected<=150000 cycles", cyc);
      report();
    end
  end

  task automatic chk(input bit ok, input string msg, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    img[bp] = b; bp++;
  endtask

  task automatic clear_img();
    for (int i = 0; i < MEMB; i++) img[i] = 8'h00;
    bp = 0; en = 0;
  endtask

  task automatic add_single(input logic [13:0] a, input logic [31:0] d);
    put({a[7:2], 2'd0}); put({2'b11, a[13:8]});
    for (int k = 0; k < 4; k++) put(d[8*k +: 8]);
    ea[en] = {a[13:2], 2'b00}; ed[en] = d; en++;
  endtask

  task automatic add_burst(input logic [13:0] a, input int n, input logic [31:0] seed);
    put({a[7:2], 2'd1}); put({2'b00, a[13:8]});
    put(8'(n)); put(8'(n >> 8));
    for (int i = 0; i < n; i++) begin
      logic [31:0] d;
      d = seed + 32'(i) * 32'h01020304;
      for (int k = 0; k < 4; k++) put(d[8*k +: 8]);
      ea[en] = {a[13:2] + 12'(i), 2'b00}; ed[en] = d; en++;
    end
  endtask

  task automatic add_done(input bit good);
    logic [7:0] s;
    put(8'h56); put(8'h2A);
    s = 8'h00;
    for (int i = 0; i < bp; i++) s = s + img[i];
    put(good ? (8'hFF - s) : (8'hFE - s));
  endtask

  task automatic run(input string tag, input logic [1:0] xerr, input int xreads, input bit poke);
    int t;
    bit ok;
    int bad_i;
    gn = 0; rd_cnt = 0; rd_bad = 0; t = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!done && t < 5000) begin
      @(negedge clk); t++;
      start = (poke && t == 8);
    end
    start = 1'b0;
    chk(done === 1'b1, {tag, " R9 done pulse seen"}, done, 1);
    chk(err_code == xerr, {tag, " R6 R7 R8 err_code"}, err_code, xerr);
    chk(cksum_fail == (xerr == 2'd1), {tag, " R6 cksum_fail"}, cksum_fail, xerr == 2'd1);
    chk(released && !busy, {tag, " R9 released and idle"}, {released, busy}, 2'b10);
    chk(gn == en, {tag, " R3 R4 R5 write count"}, gn, en);
    ok = 1; bad_i = 0;
    for (int i = 0; i < en && i < gn; i++)
      if (ok && (ga[i] != ea[i] || gd[i] != ed[i])) begin ok = 0; bad_i = i; end
    chk(ok, {tag, " R3 R4 write address/data"}, {ga[bad_i], gd[bad_i]}, {ea[bad_i], ed[bad_i]});
    chk(rd_cnt == xreads, {tag, " R2 R7 R8 bytes read"}, rd_cnt, xreads);
    chk(rd_bad == 0, {tag, " R2 sequential addresses"}, rd_bad, 0);
    @(negedge clk);
    chk(!done, {tag, " R9 done lasts one cycle"}, done, 0);
    repeat (6) @(negedge clk);
    chk(released && rd_cnt == xreads && gn == en, {tag, " R7 R9 quiet after end"}, rd_cnt, xreads);
  endtask

  initial begin
    clear_img();
    repeat (3) @(negedge clk);
    chk(!busy && !done && !released && err_code == 2'd0 && !cksum_fail,
        "R1 status in reset", {busy, done, released, err_code, cksum_fail}, 0);
    chk(!rd_req_valid && !wr_valid, "R1 no valid in reset", {rd_req_valid, wr_valid}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !released && !rd_req_valid && !wr_valid && err_code == 2'd0,
        "R1 idle after reset", {busy, released, rd_req_valid, wr_valid}, 0);

    // two single writes, good checksum
    clear_img();
    add_single(14'h0104, 32'hDEADBEEF);
    add_single(14'h3FFC, 32'h12345678);
    add_done(1);
    run("singles", 2'd0, bp, 0);

    // burst length sweep, 0 exercises R5
    for (int n = 0; n <= 5; n++) begin
      clear_img();
      add_single(14'h0040, 32'hC0DE0000 + 32'(n));
      add_burst(14'h02A0 + 14'(n * 16), n, 32'h0A0B0C0D ^ 32'(n));
      add_done(1);
      run($sformatf("burst%0d", n), 2'd0, bp, 0);
    end

    // burst wrapping across the top of the register space
    clear_img();
    add_burst(14'h3FF8, 3, 32'h55AA0001);
    add_done(1);
    run("wrap", 2'd0, bp, 0);

    // bad checksum: writes still land
    clear_img();
    add_single(14'h0010, 32'h01234567);
    add_burst(14'h0200, 2, 32'h89ABCDEF);
    add_done(0);
    run("badsum", 2'd1, bp, 0);

    // reserved type in the second header
    clear_img();
    add_single(14'h0020, 32'hFEEDF00D);
    put(8'h0F);
    run("rsvd", 2'd2, bp, 0);

    // no terminator before the end of memory
    clear_img();
    add_burst(14'h0100, 15, 32'h11110000);
    run("overrun", 2'd3, MEMB, 0);

    // start pulsed mid-load is ignored
    clear_img();
    add_single(14'h0104, 32'hDEADBEEF);
    add_burst(14'h0300, 2, 32'h76543210);
    add_done(1);
    run("poke", 2'd0, bp, 1);

    report();
  end
endmodule